// File: doc/BRIEF.md
# Shader Dispatch Coalescing Sorter

This block gathers dispatch requests whose lanes point at many different target records and regroups them into SIMD groups in which every lane targets the same record. Each request pair is a 16-bit work-item identifier plus a 64-bit target record address. Pairs arrive by two routes. A wide batch port carries up to `LANES` pairs under a per-lane valid mask. A narrow port carries a single pair per handshake.

A small associative sorting cache of `ENTRIES` slots holds partial groups. Each slot holds an address tag, a fill count, a wait counter and a row of identifiers. A slot that fills up leaves at once as a full group. A slot that has waited `age_limit` cycles leaves partially filled, so the tail of a workload drains. A new address that finds no free slot forces the longest-waiting partial slot out, so the unit always makes progress.

Groups leave through a valid/ready port that carries the shared address, a lane mask and the identifier row.

Top module: `dispatch_coalescer`

## Requirements
- R1: Batch lane k is present when `bat_mask[k]` is 1. Its identifier sits at `bat_ids[16k +: 16]` and its address at `bat_addrs[64k +: 64]`. A staged batch is inserted one lane per cycle, lowest present lane first.
- R2: Every emitted group contains only identifiers that arrived with `grp_addr`. If a group holds n identifiers, they occupy lanes 0..n-1, `grp_mask` has exactly its low n bits set, and the identifier fields of the other lanes are zero.
- R3: Every accepted identifier leaves in exactly one group: none is lost and none is duplicated.
- R4: A slot that collects `LANES` identifiers is emitted as a full group (`grp_mask` all ones), with identifiers in arrival order. A full slot takes priority over every other eviction.
- R5: A partial slot whose wait count (cycles since allocation) reaches `age_limit` is emitted. With an idle, free output and no full slot, `grp_valid` rises on the (age_limit+1)-th clock edge after the edge that allocated the slot.
- R6: When a pair brings a new address and no slot is free, the partial slot that has waited longest (lowest index on a tie) is emitted. The pair waits and is inserted on a later cycle.
- R7: While `grp_valid` is 1 and `grp_ready` is 0, the group's valid, address, mask and identifiers stay unchanged.
- R8: `bat_ready` is 0 while a staged batch still has lanes to insert. `one_ready` is 0 whenever `bat_ready` is 0.
- R9: After reset, `grp_valid` is 0 and both `bat_ready` and `one_ready` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| age_limit | input | AGE_W | Wait cycles after which a partial slot is flushed |
| bat_valid | input | 1 | Batch request valid |
| bat_ready | output | 1 | Batch request accepted when high with valid |
| bat_mask | input | LANES | Per-lane presence mask |
| bat_ids | input | LANES*ID_W | Lane identifiers, lane k at bits [ID_W*k +: ID_W] |
| bat_addrs | input | LANES*ADDR_W | Lane addresses, lane k at bits [ADDR_W*k +: ADDR_W] |
| one_valid | input | 1 | Single request valid |
| one_ready | output | 1 | Single request accepted when high with valid |
| one_id | input | ID_W | Single request identifier |
| one_addr | input | ADDR_W | Single request address |
| grp_valid | output | 1 | Group output valid |
| grp_ready | input | 1 | Downstream accepts the group |
| grp_addr | output | ADDR_W | Address shared by every lane of the group |
| grp_mask | output | LANES | Occupied lanes, contiguous from lane 0 |
| grp_ids | output | LANES*ID_W | Group identifiers, unused lanes zero |

## Verification
A wrong slot tag or a misrouted hit shows up as an identifier emitted under a foreign address. That is visible on the very group that carries it. A slot freed too early, or written twice, shows up as an identifier that never leaves or that leaves twice. The final accounting after a zero-limit flush exposes this within a few dozen cycles. A wrong wait counter or a wrong victim choice moves the edge on which a partial group appears, or changes which address it carries. Directed cases pin that edge and that address to the exact cycle.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

  // index of the lowest set bit, zero when none is set
  function automatic int unsigned lowest_set(input logic [31:0] v);
    int unsigned r;
    r = 0;
    for (int k = 31; k >= 0; k--) begin
      if (v[k]) r = k;
    end
    return r;
  endfunction

  // mask with the low n bits set
  function automatic logic [31:0] fill_low(input int unsigned n);
    logic [31:0] r;
    r = '0;
    for (int k = 0; k < 32; k++) begin
      if (k < n) r[k] = 1'b1;
    end
    return r;
  endfunction

endpackage

// File: rtl/dcs_lane_stage.sv
module dcs_lane_stage #(
  parameter int LANES  = 8,
  parameter int ID_W   = 16,
  parameter int ADDR_W = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bat_valid,
  output logic                    bat_ready,
  input  logic [LANES-1:0]        bat_mask,
  input  logic [LANES*ID_W-1:0]   bat_ids,
  input  logic [LANES*ADDR_W-1:0] bat_addrs,
  input  logic                    pop,
  output logic                    has,
  output logic [ID_W-1:0]         cur_id,
  output logic [ADDR_W-1:0]       cur_addr
);
  import dcs_pkg::*;
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;

  logic [LANES-1:0]        mask_q;
  logic [LANES*ID_W-1:0]   ids_q;
  logic [LANES*ADDR_W-1:0] addrs_q;
  logic [LW-1:0]           lane;
  logic                    bat_fire;

  assign has       = |mask_q;
  assign bat_ready = !has;
  assign bat_fire  = bat_valid && bat_ready;
  assign lane      = LW'(lowest_set(32'(mask_q)));
  assign cur_id    = ids_q[lane*ID_W +: ID_W];
  assign cur_addr  = addrs_q[lane*ADDR_W +: ADDR_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '0;
      ids_q   <= '0;
      addrs_q <= '0;
    end else if (bat_fire) begin
      mask_q  <= bat_mask;
      ids_q   <= bat_ids;
      addrs_q <= bat_addrs;
    end else if (pop) begin
      mask_q  <= mask_q & ~(LANES'(1) << lane);
    end
  end

  // R8: a nonempty batch keeps the batch port closed on the next cycle
  assert_batch_closes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bat_fire && (|bat_mask)) |=> (has && !bat_ready));

  // R1: a lane is only consumed while the stage holds one
  assert_pop_needs_lane_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> has);

endmodule

// File: rtl/dcs_sort_cache.sv
module dcs_sort_cache #(
  parameter int LANES   = 8,
  parameter int ENTRIES = 8,
  parameter int ID_W    = 16,
  parameter int ADDR_W  = 64,
  parameter int AGE_W   = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [ID_W-1:0]        in_id,
  input  logic [ADDR_W-1:0]      in_addr,
  output logic                   in_ok,
  input  logic [AGE_W-1:0]       age_limit,
  input  logic                   out_free,
  output logic                   ev_fire,
  output logic [ADDR_W-1:0]      ev_addr,
  output logic [$clog2(LANES+1)-1:0] ev_cnt,
  output logic [LANES*ID_W-1:0]  ev_ids
);
  localparam int CW = $clog2(LANES+1);
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int EW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]  v_q;
  logic [ADDR_W-1:0]   tag_q [ENTRIES];
  logic [CW-1:0]       cnt_q [ENTRIES];
  logic [AGE_W-1:0]    age_q [ENTRIES];
  logic [ID_W-1:0]     ids_q [ENTRIES][LANES];

  logic [ENTRIES-1:0]  hit_raw, hit_use, full_vec;
  logic                free_any, any_full, old_found, hit_any;
  logic [EW-1:0]       free_idx, full_idx, old_idx, hit_idx, ev_idx, ins_idx;
  logic                need_force, expired, ev_want, ins;

  always_comb begin
    free_any = 1'b0; free_idx = '0;
    any_full = 1'b0; full_idx = '0;
    for (int i = ENTRIES-1; i >= 0; i--) begin
      full_vec[i] = v_q[i] && (cnt_q[i] == CW'(LANES));
      hit_raw[i]  = v_q[i] && !full_vec[i] && (tag_q[i] == in_addr);
      if (!v_q[i])     begin free_any = 1'b1; free_idx = EW'(i); end
      if (full_vec[i]) begin any_full = 1'b1; full_idx = EW'(i); end
    end
    old_found = 1'b0; old_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (v_q[i] && !full_vec[i] && (!old_found || (age_q[i] > age_q[old_idx]))) begin
        old_found = 1'b1;
        old_idx   = EW'(i);
      end
    end
    need_force = in_valid && !(|hit_raw) && !free_any;
    expired    = old_found && (age_q[old_idx] >= age_limit);
    ev_idx     = any_full ? full_idx : old_idx;
    ev_want    = any_full || (old_found && (expired || need_force));
    ev_fire    = ev_want && out_free;
    hit_use    = hit_raw;
    if (ev_fire) hit_use[ev_idx] = 1'b0;
    hit_any = |hit_use;
    hit_idx = '0;
    for (int i = ENTRIES-1; i >= 0; i--) begin
      if (hit_use[i]) hit_idx = EW'(i);
    end
    in_ok   = hit_any || free_any;
    ins     = in_valid && in_ok;
    ins_idx = hit_any ? hit_idx : free_idx;
  end

  assign ev_addr = tag_q[ev_idx];
  assign ev_cnt  = cnt_q[ev_idx];

  for (genvar k = 0; k < LANES; k++) begin : g_ev_lane
    assign ev_ids[k*ID_W +: ID_W] = ids_q[ev_idx][k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i] <= '0;
        cnt_q[i] <= '0;
        age_q[i] <= '0;
        for (int k = 0; k < LANES; k++) ids_q[i][k] <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (ev_fire && (ev_idx == EW'(i))) begin
          v_q[i]   <= 1'b0;
          cnt_q[i] <= '0;
        end else if (ins && (ins_idx == EW'(i))) begin
          if (!hit_any) begin
            v_q[i]      <= 1'b1;
            tag_q[i]    <= in_addr;
            cnt_q[i]    <= CW'(1);
            age_q[i]    <= '0;
            ids_q[i][0] <= in_id;
          end else begin
            ids_q[i][cnt_q[i][LW-1:0]] <= in_id;
            cnt_q[i] <= cnt_q[i] + CW'(1);
            if (age_q[i] != '1) age_q[i] <= age_q[i] + AGE_W'(1);
          end
        end else if (v_q[i] && (age_q[i] != '1)) begin
          age_q[i] <= age_q[i] + AGE_W'(1);
        end
      end
    end
  end

  // R2: one address lives in at most one open slot
  assert_single_open_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_raw));

  // R3: an eviction never releases an empty slot
  assert_evict_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fire |-> (ev_cnt != '0));

  // R4: a full slot goes before anything else when the output is free
  assert_full_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (any_full && out_free) |-> (ev_fire && (ev_cnt == CW'(LANES))));

  // R5: an expired slot leaves whenever the output can take it
  assert_timeout_leaves_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && out_free) |-> ev_fire);

  // R6: a blocked new address makes room on the next cycle
  assert_force_frees_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (need_force && out_free && !any_full) |=> !(&v_q));

endmodule

// File: rtl/dcs_group_out.sv
module dcs_group_out #(
  parameter int LANES  = 8,
  parameter int ID_W   = 16,
  parameter int ADDR_W = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic [ADDR_W-1:0]          ld_addr,
  input  logic [$clog2(LANES+1)-1:0] ld_cnt,
  input  logic [LANES*ID_W-1:0]      ld_ids,
  output logic                       free,
  input  logic                       grp_ready,
  output logic                       grp_valid,
  output logic [ADDR_W-1:0]          grp_addr,
  output logic [LANES-1:0]           grp_mask,
  output logic [LANES*ID_W-1:0]      grp_ids
);
  import dcs_pkg::*;
  localparam int CW = $clog2(LANES+1);

  logic [LANES*ID_W-1:0] clean_ids;

  for (genvar k = 0; k < LANES; k++) begin : g_clean
    assign clean_ids[k*ID_W +: ID_W] = (CW'(k) < ld_cnt) ? ld_ids[k*ID_W +: ID_W] : '0;
  end

  assign free = !grp_valid || grp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grp_valid <= 1'b0;
      grp_addr  <= '0;
      grp_mask  <= '0;
      grp_ids   <= '0;
    end else if (load) begin
      grp_valid <= 1'b1;
      grp_addr  <= ld_addr;
      grp_mask  <= LANES'(fill_low(int'(ld_cnt)));
      grp_ids   <= clean_ids;
    end else if (grp_ready) begin
      grp_valid <= 1'b0;
    end
  end

  // R7: a stalled group holds still
  assert_group_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_valid && !grp_ready) |=> (grp_valid && $stable(grp_addr) &&
                                   $stable(grp_mask) && $stable(grp_ids)));

  // R2: a presented group is never empty
  assert_group_nonempty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    grp_valid |-> grp_mask[0]);

endmodule

// File: rtl/dispatch_coalescer.sv
module dispatch_coalescer #(
  parameter int LANES   = 8,
  parameter int ENTRIES = 8,
  parameter int ID_W    = 16,
  parameter int ADDR_W  = 64,
  parameter int AGE_W   = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [AGE_W-1:0]        age_limit,
  input  logic                    bat_valid,
  output logic                    bat_ready,
  input  logic [LANES-1:0]        bat_mask,
  input  logic [LANES*ID_W-1:0]   bat_ids,
  input  logic [LANES*ADDR_W-1:0] bat_addrs,
  input  logic                    one_valid,
  output logic                    one_ready,
  input  logic [ID_W-1:0]         one_id,
  input  logic [ADDR_W-1:0]       one_addr,
  output logic                    grp_valid,
  input  logic                    grp_ready,
  output logic [ADDR_W-1:0]       grp_addr,
  output logic [LANES-1:0]        grp_mask,
  output logic [LANES*ID_W-1:0]   grp_ids
);
  localparam int CW = $clog2(LANES+1);

  logic                  stg_has, stg_pop;
  logic [ID_W-1:0]       stg_id;
  logic [ADDR_W-1:0]     stg_addr;
  logic                  ins_valid, ins_ok;
  logic [ID_W-1:0]       ins_id;
  logic [ADDR_W-1:0]     ins_addr;
  logic                  out_free, ev_fire;
  logic [ADDR_W-1:0]     ev_addr;
  logic [CW-1:0]         ev_cnt;
  logic [LANES*ID_W-1:0] ev_ids;

  assign ins_valid = stg_has || one_valid;
  assign ins_id    = stg_has ? stg_id   : one_id;
  assign ins_addr  = stg_has ? stg_addr : one_addr;
  assign stg_pop   = stg_has && ins_ok;
  assign one_ready = !stg_has && ins_ok;

  dcs_lane_stage #(.LANES(LANES), .ID_W(ID_W), .ADDR_W(ADDR_W)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .bat_valid(bat_valid), .bat_ready(bat_ready), .bat_mask(bat_mask),
    .bat_ids(bat_ids), .bat_addrs(bat_addrs),
    .pop(stg_pop), .has(stg_has), .cur_id(stg_id), .cur_addr(stg_addr)
  );

  dcs_sort_cache #(.LANES(LANES), .ENTRIES(ENTRIES), .ID_W(ID_W),
                   .ADDR_W(ADDR_W), .AGE_W(AGE_W)) u_cache (
    .clk(clk), .rst_n(rst_n),
    .in_valid(ins_valid), .in_id(ins_id), .in_addr(ins_addr), .in_ok(ins_ok),
    .age_limit(age_limit), .out_free(out_free),
    .ev_fire(ev_fire), .ev_addr(ev_addr), .ev_cnt(ev_cnt), .ev_ids(ev_ids)
  );

  dcs_group_out #(.LANES(LANES), .ID_W(ID_W), .ADDR_W(ADDR_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .load(ev_fire), .ld_addr(ev_addr), .ld_cnt(ev_cnt), .ld_ids(ev_ids),
    .free(out_free), .grp_ready(grp_ready), .grp_valid(grp_valid),
    .grp_addr(grp_addr), .grp_mask(grp_mask), .grp_ids(grp_ids)
  );

  // R8: the single port opens only behind an empty batch stage
  assert_single_behind_batch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    one_ready |-> bat_ready);

endmodule

// File: tb/dispatch_coalescer_bench.sv
module dispatch_coalescer_bench;
  localparam int LANES = 8;
  localparam int ID_W = 16;
  localparam int ADDR_W = 64;
  localparam int AGE_W = 12;
  localparam int MAXID = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AGE_W-1:0] age_limit = '1;
  logic bat_valid = 1'b0, bat_ready;
  logic [LANES-1:0] bat_mask = '0;
  logic [LANES*ID_W-1:0] bat_ids = '0;
  logic [LANES*ADDR_W-1:0] bat_addrs = '0;
  logic one_valid = 1'b0, one_ready;
  logic [ID_W-1:0] one_id = '0;
  logic [ADDR_W-1:0] one_addr = '0;
  logic grp_valid, grp_ready = 1'b1;
  logic [ADDR_W-1:0] grp_addr;
  logic [LANES-1:0] grp_mask;
  logic [LANES*ID_W-1:0] grp_ids;

  always #5 clk = ~clk;

  dispatch_coalescer u_dispatch_coalescer (
    .clk(clk), .rst_n(rst_n), .age_limit(age_limit),
    .bat_valid(bat_valid), .bat_ready(bat_ready), .bat_mask(bat_mask),
    .bat_ids(bat_ids), .bat_addrs(bat_addrs),
    .one_valid(one_valid), .one_ready(one_ready), .one_id(one_id), .one_addr(one_addr),
    .grp_valid(grp_valid), .grp_ready(grp_ready), .grp_addr(grp_addr),
    .grp_mask(grp_mask), .grp_ids(grp_ids)
  );

  int compared = 0, mismatched = 0, next_id = 0, groups = 0;
  logic [ADDR_W-1:0] addr_of [MAXID];
  bit sent [MAXID];
  int seen [MAXID];
  logic [ADDR_W-1:0] last_addr;
  logic [LANES-1:0] last_mask;
  logic [LANES*ID_W-1:0] last_ids;
  logic [31:0] lfsr = 32'h1ACE_B00C;
  bit rnd_rdy = 1'b0, done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] addr_k(input int k);
    return 64'hC0DE_0000_0000_0000 + (64'(k) << 12) + 64'(k * 7);
  endfunction

  function automatic logic [31:0] step(input logic [31:0] s);
    logic [31:0] x;
    x = s ^ (s << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
    return x;
  endfunction

  // monitor away from the active edge
  logic pv = 1'b0, pr = 1'b0;
  logic [ADDR_W-1:0] pa;
  logic [LANES-1:0] pm;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pv && !pr)
        chk(grp_valid && grp_addr == pa && grp_mask == pm, "R7 hold", {grp_mask, grp_addr[55:0]}, {pm, pa[55:0]});
      if (grp_valid && grp_ready) begin
        bit ok2;
        ok2 = ((grp_mask & (grp_mask + 1'b1)) == '0) && grp_mask[0];
        for (int k = 0; k < LANES; k++) begin
          int id;
          id = int'(grp_ids[k*ID_W +: ID_W]);
          if (grp_mask[k]) begin
            if (id >= MAXID || !sent[id] || addr_of[id] != grp_addr) ok2 = 1'b0;
            else begin
              if (seen[id] != 0) begin
                mismatched++;
                $display("FAIL R3 duplicate actual=%0d expected=%0d", seen[id] + 1, 1);
              end
              seen[id]++;
            end
          end else if (id != 0) ok2 = 1'b0;
        end
        chk(ok2, "R2 group uniform", grp_addr, grp_addr);
        groups++;
        last_addr = grp_addr; last_mask = grp_mask; last_ids = grp_ids;
      end
      pv = grp_valid; pr = grp_ready; pa = grp_addr; pm = grp_mask;
    end
  end

  always @(posedge clk) begin
    #1;
    if (rnd_rdy) begin
      lfsr = step(lfsr);
      grp_ready = lfsr[3] | lfsr[7];
    end
  end

  task automatic send_one(input logic [63:0] a);
    bit acc;
    one_id = ID_W'(next_id); one_addr = a;
    addr_of[next_id] = a; sent[next_id] = 1'b1; next_id++;
    one_valid = 1'b1; acc = 1'b0;
    while (!acc) begin
      @(negedge clk); acc = one_ready;
      @(posedge clk); #1;
    end
    one_valid = 1'b0;
  endtask

  task automatic send_batch(input logic [LANES-1:0] m, input logic [LANES*ADDR_W-1:0] a);
    bit acc;
    bat_mask = m; bat_addrs = a; bat_ids = '0;
    for (int k = 0; k < LANES; k++) begin
      if (m[k]) begin
        bat_ids[k*ID_W +: ID_W] = ID_W'(next_id);
        addr_of[next_id] = a[k*ADDR_W +: ADDR_W]; sent[next_id] = 1'b1; next_id++;
      end
    end
    bat_valid = 1'b1; acc = 1'b0;
    while (!acc) begin
      @(negedge clk); acc = bat_ready;
      @(posedge clk); #1;
    end
    bat_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic flush();
    rnd_rdy = 1'b0; grp_ready = 1'b1; age_limit = '0;
    idle(40);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_up();
  end

  initial begin
    int g0, b0, s0, fid;
    logic [LANES*ADDR_W-1:0] av;
    logic [63:0] xa;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!grp_valid, "R9 grp_valid", 64'(grp_valid), 0);
    chk(bat_ready, "R9 bat_ready", 64'(bat_ready), 1);
    chk(one_ready, "R9 one_ready", 64'(one_ready), 1);
    @(posedge clk); #1;

    // R4: eight singles to one address
    age_limit = '1; g0 = groups; fid = next_id; xa = addr_k(100);
    for (int i = 0; i < LANES; i++) send_one(xa);
    idle(3);
    chk(groups == g0 + 1 && last_mask == '1 && last_addr == xa, "R4 full group", {last_mask, last_addr[55:0]}, {8'hFF, xa[55:0]});
    for (int k = 0; k < LANES; k++)
      chk(last_ids[k*ID_W +: ID_W] == ID_W'(fid + k), "R4 arrival order", last_ids[k*ID_W +: ID_W], 64'(fid + k));

    // R1/R8: one full batch, all lanes same address
    xa = addr_k(101); fid = next_id;
    for (int k = 0; k < LANES; k++) av[k*ADDR_W +: ADDR_W] = xa;
    send_batch('1, av);
    chk(!bat_ready && !one_ready, "R8 stage busy", {bat_ready, one_ready}, 0);
    idle(LANES + 3);
    chk(last_addr == xa && last_mask == '1, "R1 batch group", last_addr, xa);
    for (int k = 0; k < LANES; k++)
      chk(last_ids[k*ID_W +: ID_W] == ID_W'(fid + k), "R1 lane order", last_ids[k*ID_W +: ID_W], 64'(fid + k));

    // R5: timeout edge
    age_limit = AGE_W'(10); xa = addr_k(102);
    send_one(xa);
    idle(10);
    chk(!grp_valid, "R5 not before limit", 64'(grp_valid), 0);
    idle(1);
    chk(grp_valid && grp_addr == xa && grp_mask == 8'h01, "R5 at limit", {grp_valid, grp_addr[55:0]}, {8'h01, xa[55:0]});
    idle(3);

    // R6: forced eviction picks the longest waiter
    age_limit = '1; g0 = groups;
    for (int i = 0; i < 8; i++) send_one(addr_k(200 + i));
    idle(2);
    chk(groups == g0, "R6 no early eviction", 64'(groups - g0), 0);
    send_one(addr_k(208));
    idle(2);
    chk(groups == g0 + 1 && last_addr == addr_k(200) && last_mask == 8'h01, "R6 victim", last_addr, addr_k(200));
    flush();
    chk(groups == g0 + 9, "R6 remaining drained", 64'(groups - g0), 9);

    // R4/R1: batch split over two addresses, then one completes
    age_limit = '1; b0 = next_id;
    for (int k = 0; k < LANES; k++) av[k*ADDR_W +: ADDR_W] = (k % 2 == 0) ? addr_k(300) : addr_k(301);
    send_batch('1, av);
    s0 = next_id;
    for (int i = 0; i < 4; i++) send_one(addr_k(300));
    idle(3);
    chk(last_addr == addr_k(300) && last_mask == '1, "R4 mixed full", last_addr, addr_k(300));
    for (int k = 0; k < LANES; k++) begin
      int e;
      e = (k < 4) ? b0 + 2 * k : s0 + k - 4;
      chk(last_ids[k*ID_W +: ID_W] == ID_W'(e), "R4 mixed order", last_ids[k*ID_W +: ID_W], 64'(e));
    end
    flush();

    // sweep: spreads of addresses, wait limits, random backpressure
    for (int p = 0; p < 6; p++) begin
      int na;
      na = (p == 0) ? 1 : (p == 1) ? 2 : (p == 2) ? 3 : (p == 3) ? 5 : (p == 4) ? 8 : 11;
      age_limit = AGE_W'((p == 0) ? 3 : (p == 1) ? 60 : (p == 2) ? 7 : (p == 3) ? 15 : (p == 4) ? 1000 : 2);
      rnd_rdy = 1'b1;
      for (int it = 0; it < 40; it++) begin
        lfsr = step(lfsr);
        if (lfsr[0]) begin
          send_one(addr_k(400 + p * 16 + int'(lfsr[15:8]) % na));
        end else begin
          logic [LANES-1:0] m;
          m = lfsr[23:16];
          for (int k = 0; k < LANES; k++) begin
            lfsr = step(lfsr);
            av[k*ADDR_W +: ADDR_W] = addr_k(400 + p * 16 + int'(lfsr[11:4]) % na);
          end
          send_batch(m, av);
        end
      end
      flush();
    end

    // R3: full accounting
    begin
      int lost, dup;
      lost = 0; dup = 0;
      for (int i = 0; i < next_id; i++) begin
        if (seen[i] == 0) lost++;
        if (seen[i] > 1) dup++;
      end
      chk(lost == 0, "R3 lost ids", 64'(lost), 0);
      chk(dup == 0, "R3 duplicated ids", 64'(dup), 0);
    end
    finish_up();
  end

endmodule